// File: doc/BRIEF.md
# SDRAM-style flash command decoder

This block sits behind the pins of a synchronous flash device that speaks an SDRAM-like command protocol. On every rising clock edge with the clock-enable high, it samples the active-low select and the three strobe pins and turns them into exactly one command. It then updates the state that command touches: which of four banks hold an open row and which row that is, the last flash command code, the mode register, and a program-setup flag.

The protocol differs from a DRAM in three ways. There is no refresh, so that pin pattern instead loads a flash command code. Closing a row is optional, so the precharge pattern becomes an optional row-close that acts on one bank or on all of them. A write is refused unless a program-setup code was loaded first.

The block also drives the data-bus enables from the byte mask pin. The write path responds in the same cycle. The read path responds after a fixed latency set by a parameter.

Top module: `flash_cmd_front`

## Requirements
- R1: While `cke` is high, each rising edge registers one command on `cmd_seen`. With `cs_n` high the value is 0 (inhibit). With `cs_n` low, the pattern {ras_n,cas_n,we_n} maps as follows: 111 gives 1 (no-op), 011 gives 2 (open row), 101 gives 3 (read), 100 gives 4 (write), 110 gives 5 (burst stop), 010 gives 6 (row close), 001 gives 7 (load command code), 000 gives 8 (load mode).
- R2: An open-row command sets the `bank_open` bit selected by `ba` and stores `addr[11:0]` into that bank's 12-bit slice of `bank_rows` (bank n at bits n*12+11..n*12). Opening a bank that is already open replaces its row.
- R3: A row-close command with `addr[10]` low clears only the bank named by `ba`. With `addr[10]` high it clears all four banks, whatever `ba` holds.
- R4: A read or write to an open bank is accepted. For an accepted read, `rd_go` pulses for one cycle and `acc_bank`/`acc_col` take `ba`/`addr[7:0]`. A read or write to a closed bank pulses `err_nobank` instead and changes nothing else.
- R5: A load-command-code command stores `addr[7:0]` into `code_reg` and ignores `addr[11:8]`. It sets `prog_armed` when the code equals the program-setup code (default 8'h40) and clears it for any other code.
- R6: A write to an open bank is accepted only while `prog_armed` is set. An accepted write pulses `wr_go`, captures bank and column, and clears `prog_armed`. A write to an open bank without it pulses `err_wrgate`.
- R7: Load-mode writes `addr[11:0]` into `mode_reg`, but only if at least TMRD enabled cycles (default 2) have passed since the last accepted load. An earlier load pulses `err_mrd` and leaves `mode_reg` unchanged.
- R8: Synchronous reset closes all banks and clears `prog_armed`, `code_reg`, `acc_bank`, `acc_col`, all pulses and `rd_dq_en`. It sets `cmd_seen` to 0 and loads `mode_reg` with MODE_RST (default 12'h022).
- R9: `wr_dq_en` equals the inverse of `dqm` with no delay. `rd_dq_en` shows the inverse of the `dqm` value sampled RD_LAT enabled edges earlier (default 2): the value sampled at one edge appears after the following edge.
- R10: While `cke` is low, no command is decoded, all state and `rd_dq_en` hold, and `rd_go`, `wr_go` and the error pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| dqm | input | 1 | Data mask; high disables the data bus |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus: row, column, code or mode value |
| cmd_seen | output | 4 | Last decoded command code |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| bank_rows | output | 48 | Open row of each bank, 12 bits per bank |
| rd_go | output | 1 | Accepted read pulse |
| wr_go | output | 1 | Accepted write pulse |
| acc_bank | output | 2 | Bank of the last accepted access |
| acc_col | output | 8 | Column of the last accepted access |
| code_reg | output | 8 | Last loaded flash command code |
| prog_armed | output | 1 | Program setup done; a write may proceed |
| mode_reg | output | 12 | Mode register |
| err_nobank | output | 1 | Pulse: access to a bank with no open row |
| err_wrgate | output | 1 | Pulse: write without program setup |
| err_mrd | output | 1 | Pulse: mode load inside the guard window |
| wr_dq_en | output | 1 | Write data enable, zero latency |
| rd_dq_en | output | 1 | Read output enable, delayed |

## Verification
Two behaviours can meet in one cycle: the read enable, still carrying the mask of a read issued two edges earlier, and the same-cycle write enable of a new write. The bench issues a read with the mask high and follows it at once with writes carrying the opposite mask, then checks both enables on each of those cycles against a model that keeps the read path as a queue. A second meeting point is a mode load that lands exactly on the cycle the guard window expires, next to one that lands a cycle too early. The bench provokes both loads back to back and checks the error pulse and the register value on each cycle.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 8;
    localparam int CODE_W = 8;
    localparam int ALL_BIT = 10;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_READ    = 4'd3,
        CMD_WRITE   = 4'd4,
        CMD_BSTOP   = 4'd5,
        CMD_ATERM   = 4'd6,
        CMD_LDCODE  = 4'd7,
        CMD_LDMODE  = 4'd8
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    typedef struct packed {
        cmd_e               cmd;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   addr;
    } req_t;

    function automatic cmd_e pin_decode(pins_t p);
        cmd_e c;
        if (p.cs_n) begin
            c = CMD_INHIBIT;
        end else begin
            case ({p.ras_n, p.cas_n, p.we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b110:  c = CMD_BSTOP;
                3'b010:  c = CMD_ATERM;
                3'b001:  c = CMD_LDCODE;
                3'b000:  c = CMD_LDMODE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/fcf_decode.sv
module fcf_decode
    import fcf_pkg::*;
(
    input  logic              cke,
    input  pins_t             pins,
    input  logic [BANK_W-1:0] ba,
    input  logic [ROW_W-1:0]  addr,
    output req_t              req,
    output logic              en
);
    assign en       = cke;
    assign req.cmd  = pin_decode(pins);
    assign req.bank = ba;
    assign req.addr = addr;
endmodule

// File: rtl/fcf_bank_table.sv
module fcf_bank_table
    import fcf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  req_t                    req,
    output logic [NBANK-1:0]        open_o,
    output logic [NBANK*ROW_W-1:0]  rows_o
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic             r_open;
        logic [ROW_W-1:0] r_row;
        logic             sel;

        assign sel = (req.bank == BANK_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_open <= 1'b0;
                r_row  <= '0;
            end else if (en) begin
                if (req.cmd == CMD_ACT && sel) begin
                    r_open <= 1'b1;
                    r_row  <= req.addr;
                end else if (req.cmd == CMD_ATERM && (req.addr[ALL_BIT] || sel)) begin
                    r_open <= 1'b0;
                end
            end
        end

        assign open_o[g]                  = r_open;
        assign rows_o[g*ROW_W +: ROW_W]   = r_row;
    end

    AST_CLOSE_ALL: assert property (@(posedge clk) disable iff (rst)
        (en && req.cmd == CMD_ATERM && req.addr[ALL_BIT]) |=> (open_o == '0)); // R3

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (en && req.cmd == CMD_ACT) |=> open_o[$past(req.bank)]); // R2
endmodule

// File: rtl/fcf_mode_guard.sv
module fcf_mode_guard
    import fcf_pkg::*;
#(
    parameter int               TMRD     = 2,
    parameter logic [ROW_W-1:0] MODE_RST = 12'h022
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [ROW_W-1:0] value,
    output logic [ROW_W-1:0] mode_o,
    output logic             early_o
);
    localparam int CW = $clog2(TMRD + 1);

    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= '0;
            mode_o  <= MODE_RST;
            early_o <= 1'b0;
        end else begin
            early_o <= 1'b0;
            if (en) begin
                if (load && wait_q == '0) begin
                    mode_o <= value;
                    wait_q <= CW'(TMRD - 1);
                end else begin
                    if (load) begin
                        early_o <= 1'b1;
                    end
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
            end
        end
    end

    AST_EARLY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        early_o |-> $stable(mode_o)); // R7
endmodule

// File: rtl/fcf_dqm_pipe.sv
module fcf_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dqm,
    output logic wr_o,
    output logic rd_o
);
    assign wr_o = ~dqm;

    if (RD_LAT <= 1) begin : g_one
        logic rq;
        always_ff @(posedge clk) begin
            if (rst)     rq <= 1'b0;
            else if (en) rq <= ~dqm;
        end
        assign rd_o = rq;
    end else begin : g_multi
        logic [RD_LAT-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst)     sr <= '0;
            else if (en) sr <= {sr[RD_LAT-2:0], ~dqm};
        end
        assign rd_o = sr[RD_LAT-1];
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(rd_o)); // R10
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import fcf_pkg::*;
#(
    parameter int                TMRD     = 2,
    parameter int                RD_LAT   = 2,
    parameter logic [ROW_W-1:0]  MODE_RST = 12'h022,
    parameter logic [CODE_W-1:0] PGM_CODE = 8'h40
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   dqm,
    input  logic [BANK_W-1:0]      ba,
    input  logic [ROW_W-1:0]       addr,
    output logic [3:0]             cmd_seen,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] bank_rows,
    output logic                   rd_go,
    output logic                   wr_go,
    output logic [BANK_W-1:0]      acc_bank,
    output logic [COL_W-1:0]       acc_col,
    output logic [CODE_W-1:0]      code_reg,
    output logic                   prog_armed,
    output logic [ROW_W-1:0]       mode_reg,
    output logic                   err_nobank,
    output logic                   err_wrgate,
    output logic                   err_mrd,
    output logic                   wr_dq_en,
    output logic                   rd_dq_en
);
    req_t  req;
    logic  en;
    pins_t pins;

    assign pins = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    fcf_decode u_dec (
        .cke  (cke),
        .pins (pins),
        .ba   (ba),
        .addr (addr),
        .req  (req),
        .en   (en)
    );

    fcf_bank_table u_banks (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .req    (req),
        .open_o (bank_open),
        .rows_o (bank_rows)
    );

    fcf_mode_guard #(.TMRD(TMRD), .MODE_RST(MODE_RST)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .load    (req.cmd == CMD_LDMODE),
        .value   (req.addr),
        .mode_o  (mode_reg),
        .early_o (err_mrd)
    );

    fcf_dqm_pipe #(.RD_LAT(RD_LAT)) u_dqm (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .dqm  (dqm),
        .wr_o (wr_dq_en),
        .rd_o (rd_dq_en)
    );

    cmd_e cmd_q;
    logic armed_q;
    logic is_rd, is_wr, hit;
    logic rd_ok, wr_ok, miss, gated;

    assign is_rd = en && (req.cmd == CMD_READ);
    assign is_wr = en && (req.cmd == CMD_WRITE);
    assign hit   = bank_open[req.bank];
    assign rd_ok = is_rd && hit;
    assign wr_ok = is_wr && hit && armed_q;
    assign miss  = (is_rd || is_wr) && !hit;
    assign gated = is_wr && hit && !armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= CMD_INHIBIT;
            armed_q    <= 1'b0;
            code_reg   <= '0;
            acc_bank   <= '0;
            acc_col    <= '0;
            rd_go      <= 1'b0;
            wr_go      <= 1'b0;
            err_nobank <= 1'b0;
            err_wrgate <= 1'b0;
        end else begin
            rd_go      <= rd_ok;
            wr_go      <= wr_ok;
            err_nobank <= miss;
            err_wrgate <= gated;
            if (en) begin
                cmd_q <= req.cmd;
            end
            if (rd_ok || wr_ok) begin
                acc_bank <= req.bank;
                acc_col  <= req.addr[COL_W-1:0];
            end
            if (en && req.cmd == CMD_LDCODE) begin
                code_reg <= req.addr[CODE_W-1:0];
                armed_q  <= (req.addr[CODE_W-1:0] == PGM_CODE);
            end else if (wr_ok) begin
                armed_q  <= 1'b0;
            end
        end
    end

    assign cmd_seen   = cmd_q;
    assign prog_armed = armed_q;

    AST_RD_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> bank_open[acc_bank]); // R4

    AST_WR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> !prog_armed); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_go, wr_go, err_nobank, err_wrgate, err_mrd})); // R1

    AST_CKE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(bank_open) && $stable(mode_reg) && $stable(code_reg)
                  && !rd_go && !wr_go)); // R10
endmodule

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb;

    localparam int TMRD   = 2;
    localparam int RD_LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;

    logic [3:0]  cmd_seen;
    logic [3:0]  bank_open;
    logic [47:0] bank_rows;
    logic        rd_go, wr_go, prog_armed, err_nobank, err_wrgate, err_mrd, wr_dq_en, rd_dq_en;
    logic [1:0]  acc_bank;
    logic [7:0]  acc_col, code_reg;
    logic [11:0] mode_reg;

    always #4 clk = ~clk;

    flash_cmd_front u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr), .cmd_seen(cmd_seen),
        .bank_open(bank_open), .bank_rows(bank_rows), .rd_go(rd_go), .wr_go(wr_go),
        .acc_bank(acc_bank), .acc_col(acc_col), .code_reg(code_reg),
        .prog_armed(prog_armed), .mode_reg(mode_reg), .err_nobank(err_nobank),
        .err_wrgate(err_wrgate), .err_mrd(err_mrd), .wr_dq_en(wr_dq_en), .rd_dq_en(rd_dq_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R8";

    // reference model state
    int          m_cmd;
    bit          m_open [4];
    logic [11:0] m_row [4];
    bit          m_armed, m_rd, m_wr, m_nb, m_gate, m_mrd, m_rde;
    logic [7:0]  m_code, m_col;
    logic [1:0]  m_bank;
    logic [11:0] m_mode;
    int          m_wait;
    bit          rq[$];

    task automatic model_reset();
        m_cmd = 0; m_armed = 0; m_rd = 0; m_wr = 0; m_nb = 0; m_gate = 0; m_mrd = 0;
        m_rde = 0; m_code = 0; m_col = 0; m_bank = 0; m_mode = 12'h022; m_wait = 0;
        for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
        rq.delete();
        for (int i = 0; i < RD_LAT - 1; i++) rq.push_back(1'b0);
    endtask

    task automatic model_edge();
        int c;
        m_rd = 0; m_wr = 0; m_nb = 0; m_gate = 0; m_mrd = 0;
        if (!cke) return;
        if (cs_n) c = 0;
        else case ({ras_n, cas_n, we_n})
            3'b111: c = 1; 3'b011: c = 2; 3'b101: c = 3; 3'b100: c = 4;
            3'b110: c = 5; 3'b010: c = 6; 3'b001: c = 7; default: c = 8;
        endcase
        m_cmd = c;
        if (c == 2) begin m_open[ba] = 1; m_row[ba] = addr; end
        if (c == 3 || c == 4) begin
            if (!m_open[ba]) m_nb = 1;
            else if (c == 4 && !m_armed) m_gate = 1;
            else begin
                if (c == 3) m_rd = 1; else begin m_wr = 1; m_armed = 0; end
                m_bank = ba; m_col = addr[7:0];
            end
        end
        if (c == 6) begin
            if (addr[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
            else m_open[ba] = 0;
        end
        if (c == 7) begin m_code = addr[7:0]; m_armed = (addr[7:0] == 8'h40); end
        if (c == 8 && m_wait == 0) begin
            m_mode = addr; m_wait = TMRD - 1;
        end else begin
            if (c == 8) m_mrd = 1;
            if (m_wait > 0) m_wait--;
        end
        m_rde = rq.pop_front();
        rq.push_back(!dqm);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at %0t: actual=%0h expected=%0h", tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 cmd_seen", cmd_seen, m_cmd);
        for (int i = 0; i < 4; i++) begin
            chk("R2/R3 bank_open", bank_open[i], m_open[i]);
            chk("R2 bank_rows", bank_rows[i*12 +: 12], m_row[i]);
        end
        chk("R4 rd_go", rd_go, m_rd);
        chk("R4 err_nobank", err_nobank, m_nb);
        chk("R4 acc_bank", acc_bank, m_bank);
        chk("R4 acc_col", acc_col, m_col);
        chk("R5 code_reg", code_reg, m_code);
        chk("R6 prog_armed", prog_armed, m_armed);
        chk("R6 wr_go", wr_go, m_wr);
        chk("R6 err_wrgate", err_wrgate, m_gate);
        chk("R7 mode_reg", mode_reg, m_mode);
        chk("R7 err_mrd", err_mrd, m_mrd);
        chk("R9 wr_dq_en", wr_dq_en, !dqm);
        chk("R9 rd_dq_en", rd_dq_en, m_rde);
    endtask

    // code: 0 inhibit,1 nop,2 open,3 read,4 write,5 stop,6 close,7 code,8 mode
    task automatic issue(input bit k, input int code, input logic [1:0] b,
                         input logic [11:0] a, input bit dq);
        logic [2:0] p;
        case (code)
            2: p = 3'b011; 3: p = 3'b101; 4: p = 3'b100; 5: p = 3'b110;
            6: p = 3'b010; 7: p = 3'b001; 8: p = 3'b000;
            0: p = 3'b000; default: p = 3'b111;
        endcase
        cke = k; cs_n = (code == 0); {ras_n, cas_n, we_n} = p;
        ba = b; addr = a; dqm = dq;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cmd(input int code, input logic [1:0] b, input logic [11:0] a, input bit dq);
        issue(1'b1, code, b, a, dq);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        phase = "R8";
        compare();

        phase = "R1";
        cmd(1, 0, 12'h000, 1);
        cmd(0, 0, 12'h000, 1);
        cmd(5, 0, 12'h000, 1);

        phase = "R4";
        cmd(3, 1, 12'h011, 1);
        cmd(4, 2, 12'h022, 1);

        phase = "R2";
        cmd(2, 1, 12'hABC, 1);
        cmd(2, 2, 12'h123, 1);
        cmd(2, 1, 12'h456, 1);

        phase = "R4";
        cmd(3, 1, 12'hF5A, 0);
        phase = "R6";
        cmd(4, 1, 12'h033, 0);

        phase = "R5";
        cmd(7, 0, 12'hF40, 1);
        phase = "R6";
        cmd(4, 2, 12'h033, 0);
        cmd(4, 2, 12'h034, 0);
        phase = "R5";
        cmd(7, 0, 12'h041, 1);
        cmd(7, 0, 12'h040, 1);
        cmd(7, 0, 12'h010, 1);
        cmd(7, 0, 12'h040, 1);

        phase = "R9";
        cmd(3, 1, 12'h077, 1);
        cmd(4, 2, 12'h078, 0);
        cmd(3, 2, 12'h079, 0);
        cmd(1, 0, 12'h000, 1);
        cmd(1, 0, 12'h000, 0);
        cmd(1, 0, 12'h000, 1);

        phase = "R7";
        cmd(8, 0, 12'h155, 1);
        cmd(8, 0, 12'h2AA, 1);
        cmd(8, 0, 12'h3C3, 1);
        cmd(1, 0, 12'h000, 1);
        cmd(8, 0, 12'h0F0, 1);

        phase = "R10";
        issue(1'b0, 2, 3, 12'h999, 0);
        issue(1'b0, 8, 0, 12'h777, 1);
        issue(1'b0, 7, 0, 12'h040, 0);
        issue(1'b0, 3, 1, 12'h012, 1);
        cmd(1, 0, 12'h000, 1);

        phase = "R3";
        cmd(2, 0, 12'h100, 1);
        cmd(2, 3, 12'h333, 1);
        cmd(6, 1, 12'h000, 1);
        cmd(3, 1, 12'h001, 1);
        cmd(6, 0, 12'h400, 1);
        cmd(3, 3, 12'h002, 1);

        phase = "mixed";
        for (int i = 0; i < 600; i++) begin
            int c = $urandom_range(0, 8);
            logic [11:0] a = 12'($urandom);
            if (c == 7 && $urandom_range(0, 1) == 1) a[7:0] = 8'h40;
            issue(($urandom_range(0, 7) != 0), c, 2'($urandom), a, 1'($urandom));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (phase %s)", phase);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule